// File: doc/BRIEF.md
# Program Lock and Encrypted Verify Guard

This block sits between the on-chip program memory and everything that wants to read or write it. It holds three one-way protection bits and a 64-entry table of scramble bytes. The scramble bytes start as all ones. When the memory is read back in verify mode, the guard combines the raw code byte with a table byte picked by the read address, so that a protected image reads back scrambled. It also counts programming pulses and decides when a code byte, a table byte or a protection bit is committed. From the protection bits it derives a protection level. The level drives the permission flags for table-lookup reads from external code, for programming, for verify and for external execution.

The external-access pin is passed through while the part is unprotected. Once any protection bit is set, the guard uses the pin value sampled on the last clock of reset and holds it until the next reset. The protection bits and the table contents are non-volatile state. A reset does not clear them. A wipe strobe returns every table byte to all ones but leaves the protection bits set. Identity reads return fixed bytes from three addresses.

Top module: `code_guard`

## Requirements
- R1: With `rd_verify` as the only mode input high and verify permitted, `vfy_valid` is 1 two clock edges later and `vfy_data` equals `~(code_in ^ K)`. K is the table byte selected by `addr[5:0]`; the upper address bits play no part in the selection.
- R2: A table entry that was never programmed, or that was cleared by a one-cycle `wipe` pulse, acts as 8'hFF, so verify returns `code_in` unchanged.
- R3: While `pgm_code` is the only mode input high and programming is permitted, `code_commit` pulses for one cycle after the 5th `pgm_strobe`. Four strobes followed by dropping the mode produce no commit.
- R4: With `pgm_key` held (table write of `wr_data` at index `addr[5:0]`) or `pgm_lock` held (setting protection bit `lock_sel`, where 0, 1 and 2 are the three bits), the commit happens on the 25th strobe. Dropping the mode after 24 strobes commits nothing.
- R5: The level is the index plus one of the highest protection bit that is set, so any non-cumulative combination takes the level of its highest bit. `movc_ok` and `pgm_ok` are 1 only at level 0. `vfy_ok` is 1 below level 2. `ext_ok` is 1 below level 3. During reset all four flags are 0.
- R6: At level 1 or above, strobes under `pgm_code` or `pgm_key` are ignored: no `code_commit`, and the table is unchanged. Protection bits can still be programmed.
- R7: At level 2 or above, a verify read returns `vfy_valid` = 0 and `vfy_data` = 0.
- R8: At level 0, `ea_eff` follows `ea_pin` one edge later. At level 1 or above, `ea_eff` holds the `ea_pin` value sampled on the last clock with `rst` high.
- R9: Protection bits are never cleared by `rst` or by `wipe`.
- R10: Identity reads (`rd_sig` only) return 8'h89 at address 16'h0030, 8'h58 at 16'h0031, 8'hC0 plus SIZE_CODE (8'hC2 by default) at 16'h0060, and 8'hFF anywhere else. The latency is the same as a verify read, and these reads are allowed at every level.
- R11: If no mode input is high, or more than one of `pgm_code`, `pgm_key`, `pgm_lock`, `rd_verify` and `rd_sig` is high, nothing is committed and `vfy_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the window in which the external-access pin is sampled |
| ea_pin | input | 1 | External-access pin level |
| addr | input | 16 | Verify, identity or programming address |
| code_in | input | 8 | Raw byte from the code array |
| wr_data | input | 8 | Byte to be written into the scramble table |
| lock_sel | input | 2 | Protection bit to program (0..2) |
| pgm_code | input | 1 | Code-array programming mode |
| pgm_key | input | 1 | Scramble-table programming mode |
| pgm_lock | input | 1 | Protection-bit programming mode |
| rd_verify | input | 1 | Verify read mode |
| rd_sig | input | 1 | Identity read mode |
| pgm_strobe | input | 1 | One-cycle programming pulse |
| wipe | input | 1 | Erase strobe: returns the table to all ones |
| vfy_data | output | 8 | Read-back byte |
| vfy_valid | output | 1 | Read-back byte is valid |
| code_commit | output | 1 | Write strobe to the code array |
| movc_ok | output | 1 | External code may read internal bytes |
| pgm_ok | output | 1 | Code and table programming permitted |
| vfy_ok | output | 1 | Verify permitted |
| ext_ok | output | 1 | External execution permitted |
| ea_eff | output | 1 | External-access value in force |

## Verification
Verify reads are first issued against a blank table with random addresses and code bytes. Any change to the read-back there points at the default-table logic rather than the scramble path. Table entries at index 0 and 63 and random indices are then programmed and read back through addresses with random upper bits, which separates indexing by the low six bits from indexing by the full address. Strobe counts of 4, 5, 24 and 25, and overlapping mode inputs, tell a correct commit threshold apart from an off-by-one or a missing mode qualifier. The sequence then steps through levels 1 and 3. Reset and wipe are applied in between, to show that the protection bits persist, that the pin value is latched, and that verify is blocked while identity reads still work.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_CODE = 2'd1,
    PK_LOCK = 2'd2,
    PK_KEY  = 2'd3
  } pgm_kind_e;

  localparam logic [15:0] ID_ADDR_A = 16'h0030;
  localparam logic [15:0] ID_ADDR_B = 16'h0031;
  localparam logic [15:0] ID_ADDR_C = 16'h0060;
  localparam logic [7:0]  ID_BYTE_A = 8'h89;
  localparam logic [7:0]  ID_BYTE_B = 8'h58;
  localparam logic [7:0]  ID_BYTE_C = 8'hC0;
endpackage

// File: rtl/cg_pulse_ctr.sv
module cg_pulse_ctr
  import code_guard_pkg::*;
#(
  parameter int CODE_PULSES = 5,
  parameter int PROT_PULSES = 25,
  parameter int IDX_W       = 6,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  pgm_kind_e         kind,
  input  logic              strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  input  logic [SEL_W-1:0]  sel,
  output logic              commit_o,
  output pgm_kind_e         commit_kind_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic [SEL_W-1:0]  commit_sel_o
);
  localparam int CNT_W = $clog2(PROT_PULSES + 1);

  logic [CNT_W-1:0] cnt_q, base, target;
  pgm_kind_e        kind_q;

  always_comb begin
    target = (kind == PK_CODE) ? CNT_W'(CODE_PULSES) : CNT_W'(PROT_PULSES);
    base   = (kind != kind_q) ? '0 : cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q         <= '0;
      kind_q        <= PK_NONE;
      commit_o      <= 1'b0;
      commit_kind_o <= PK_NONE;
      commit_idx_o  <= '0;
      commit_data_o <= '0;
      commit_sel_o  <= '0;
    end else begin
      kind_q   <= kind;
      commit_o <= 1'b0;
      if (kind == PK_NONE) begin
        cnt_q <= '0;
      end else if (strobe) begin
        if (base + 1'b1 == target) begin
          cnt_q         <= '0;
          commit_o      <= 1'b1;
          commit_kind_o <= kind;
          commit_idx_o  <= idx;
          commit_data_o <= data;
          commit_sel_o  <= sel;
        end else begin
          cnt_q <= base + 1'b1;
        end
      end else begin
        cnt_q <= base;
      end
    end
  end

  // R4: the count never reaches the longer threshold without committing
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(PROT_PULSES));

  // R3: a commit needs several strobes, so commits never come back to back
  assert_commit_spaced_R3: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);
endmodule

// File: rtl/cg_lock_ctrl.sv
module cg_lock_ctrl #(
  parameter int LOCK_N = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [SEL_W-1:0] set_sel,
  input  logic             ea_pin,
  output logic             movc_ok,
  output logic             pgm_ok,
  output logic             vfy_ok,
  output logic             ext_ok,
  output logic             ea_eff
);
  localparam int LVL_W   = $clog2(LOCK_N + 1);
  localparam int VFY_LVL = 2;
  localparam int EXT_LVL = 3;

  logic [LOCK_N-1:0] lock_q = '0;
  logic [LVL_W-1:0]  lvl;
  logic              ea_latch_q;

  always_ff @(posedge clk) begin
    if (set_en && (int'(set_sel) < LOCK_N)) lock_q[set_sel] <= 1'b1;
  end

  always_comb begin
    lvl = '0;
    for (int i = 0; i < LOCK_N; i++) begin
      if (lock_q[i]) lvl = LVL_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_latch_q <= ea_pin;
      movc_ok    <= 1'b0;
      pgm_ok     <= 1'b0;
      vfy_ok     <= 1'b0;
      ext_ok     <= 1'b0;
      ea_eff     <= 1'b0;
    end else begin
      movc_ok <= (lvl == '0);
      pgm_ok  <= (lvl == '0);
      vfy_ok  <= (int'(lvl) < VFY_LVL);
      ext_ok  <= (int'(lvl) < EXT_LVL);
      ea_eff  <= (lvl != '0) ? ea_latch_q : ea_pin;
    end
  end

  // R9: protection bits are one-way
  assert_lock_oneway_R9: assert property (@(posedge clk) disable iff (rst)
    (lock_q & $past(lock_q)) == $past(lock_q));

  // R8: latched pin value is frozen outside reset
  assert_ea_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(ea_latch_q));
endmodule

// File: rtl/cg_enc_array.sv
module cg_enc_array #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wipe,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DATA_W-1:0]        rd_byte
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  used_q = '0;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_used_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (wipe) used_q <= '0;
    else if (wr_en) used_q[wr_idx] <= 1'b1;
    rd_used_q <= used_q[rd_idx];
  end

  assign rd_byte = rd_used_q ? rd_data_q : '1;

  // R2: a wipe leaves every entry at its blank value
  assert_wipe_blank_R2: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (used_q == '0));

  // R1: a write marks its entry as holding a programmed byte
  assert_write_marks_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wipe) |=> used_q[$past(wr_idx)]);

  logic unused_w;
  assign unused_w = ^{IDX_W};
endmodule

// File: rtl/code_guard.sv
module code_guard
  import code_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int KEY_DEPTH   = 64,
  parameter int LOCK_N      = 3,
  parameter int CODE_PULSES = 5,
  parameter int PROT_PULSES = 25,
  parameter int SIZE_CODE   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ea_pin,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         code_in,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [$clog2(LOCK_N)-1:0] lock_sel,
  input  logic                      pgm_code,
  input  logic                      pgm_key,
  input  logic                      pgm_lock,
  input  logic                      rd_verify,
  input  logic                      rd_sig,
  input  logic                      pgm_strobe,
  input  logic                      wipe,
  output logic [DATA_W-1:0]         vfy_data,
  output logic                      vfy_valid,
  output logic                      code_commit,
  output logic                      movc_ok,
  output logic                      pgm_ok,
  output logic                      vfy_ok,
  output logic                      ext_ok,
  output logic                      ea_eff
);
  localparam int IDX_W = $clog2(KEY_DEPTH);
  localparam int SEL_W = $clog2(LOCK_N);

  logic        one_mode;
  pgm_kind_e   kind;
  logic        cm_en;
  pgm_kind_e   cm_kind;
  logic [IDX_W-1:0]  cm_idx;
  logic [DATA_W-1:0] cm_data;
  logic [SEL_W-1:0]  cm_sel;
  logic [DATA_W-1:0] key_byte;
  logic [DATA_W-1:0] id_byte;

  logic              rd_q, sig_q, sig2_q;
  logic [DATA_W-1:0] code_q;
  logic [ADDR_W-1:0] addr_q;

  assign one_mode = ($countones({pgm_code, pgm_key, pgm_lock, rd_verify, rd_sig}) == 1);

  always_comb begin
    kind = PK_NONE;
    if (one_mode) begin
      if (pgm_code && pgm_ok)     kind = PK_CODE;
      else if (pgm_key && pgm_ok) kind = PK_KEY;
      else if (pgm_lock)          kind = PK_LOCK;
    end
  end

  cg_pulse_ctr #(
    .CODE_PULSES(CODE_PULSES), .PROT_PULSES(PROT_PULSES),
    .IDX_W(IDX_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_ctr (
    .clk(clk), .rst(rst), .kind(kind), .strobe(pgm_strobe),
    .idx(addr[IDX_W-1:0]), .data(wr_data), .sel(lock_sel),
    .commit_o(cm_en), .commit_kind_o(cm_kind), .commit_idx_o(cm_idx),
    .commit_data_o(cm_data), .commit_sel_o(cm_sel)
  );

  cg_lock_ctrl #(.LOCK_N(LOCK_N), .SEL_W(SEL_W)) u_lock (
    .clk(clk), .rst(rst),
    .set_en(cm_en && (cm_kind == PK_LOCK)), .set_sel(cm_sel),
    .ea_pin(ea_pin),
    .movc_ok(movc_ok), .pgm_ok(pgm_ok), .vfy_ok(vfy_ok),
    .ext_ok(ext_ok), .ea_eff(ea_eff)
  );

  cg_enc_array #(.DEPTH(KEY_DEPTH), .DATA_W(DATA_W)) u_key (
    .clk(clk), .rst(rst),
    .wr_en(cm_en && (cm_kind == PK_KEY)), .wr_idx(cm_idx), .wr_data(cm_data),
    .wipe(wipe), .rd_idx(addr[IDX_W-1:0]), .rd_byte(key_byte)
  );

  assign code_commit = cm_en && (cm_kind == PK_CODE);

  always_comb begin
    if (addr_q == ADDR_W'(ID_ADDR_A))      id_byte = DATA_W'(ID_BYTE_A);
    else if (addr_q == ADDR_W'(ID_ADDR_B)) id_byte = DATA_W'(ID_BYTE_B);
    else if (addr_q == ADDR_W'(ID_ADDR_C)) id_byte = DATA_W'(ID_BYTE_C) | DATA_W'(SIZE_CODE);
    else                                   id_byte = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      sig_q     <= 1'b0;
      code_q    <= '0;
      addr_q    <= '0;
      vfy_valid <= 1'b0;
      vfy_data  <= '0;
      sig2_q    <= 1'b0;
    end else begin
      rd_q      <= one_mode && ((rd_verify && vfy_ok) || rd_sig);
      sig_q     <= rd_sig;
      code_q    <= code_in;
      addr_q    <= addr;
      vfy_valid <= rd_q;
      sig2_q    <= sig_q;
      if (!rd_q)      vfy_data <= '0;
      else if (sig_q) vfy_data <= id_byte;
      else            vfy_data <= ~(code_q ^ key_byte);
    end
  end

  // R6: a code write strobe only follows a cycle in which programming was allowed
  assert_commit_perm_R6: assert property (@(posedge clk) disable iff (rst)
    code_commit |-> $past(pgm_ok));

  // R7: verify data only appears when verify was permitted at capture
  assert_vfy_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (vfy_valid && !sig2_q) |-> $past(vfy_ok, 2));

  // R11: valid read-back needs a read mode two cycles earlier
  assert_valid_src_R11: assert property (@(posedge clk) disable iff (rst)
    vfy_valid |-> $past(rd_verify || rd_sig, 2));
endmodule

// File: tb/code_guard_tb.sv
module code_guard_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          ea_pin;
  logic [AW-1:0] addr;
  logic [DW-1:0] code_in, wr_data;
  logic [1:0]    lock_sel;
  logic          pgm_code, pgm_key, pgm_lock, rd_verify, rd_sig, pgm_strobe, wipe;
  logic [DW-1:0] vfy_data;
  logic          vfy_valid, code_commit, movc_ok, pgm_ok, vfy_ok, ext_ok, ea_eff;

  always #4 clk = ~clk;

  code_guard dut_i (
    .clk(clk), .rst(rst), .ea_pin(ea_pin), .addr(addr), .code_in(code_in),
    .wr_data(wr_data), .lock_sel(lock_sel), .pgm_code(pgm_code), .pgm_key(pgm_key),
    .pgm_lock(pgm_lock), .rd_verify(rd_verify), .rd_sig(rd_sig),
    .pgm_strobe(pgm_strobe), .wipe(wipe), .vfy_data(vfy_data),
    .vfy_valid(vfy_valid), .code_commit(code_commit), .movc_ok(movc_ok),
    .pgm_ok(pgm_ok), .vfy_ok(vfy_ok), .ext_ok(ext_ok), .ea_eff(ea_eff)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] key_m [64];
  bit   [2:0] lb_m;

  function automatic int lvl_of(bit [2:0] lb);
    return lb[2] ? 3 : lb[1] ? 2 : lb[0] ? 1 : 0;
  endfunction

  function automatic logic [7:0] id_exp(logic [15:0] a);
    case (a)
      16'h0030: return 8'h89;
      16'h0031: return 8'h58;
      16'h0060: return 8'hC2;
      default:  return 8'hFF;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_perms(string tag);
    int l = lvl_of(lb_m);
    chk({tag, " movc_ok"}, 32'(movc_ok), 32'(l == 0));
    chk({tag, " pgm_ok"},  32'(pgm_ok),  32'(l == 0));
    chk({tag, " vfy_ok"},  32'(vfy_ok),  32'(l < 2));
    chk({tag, " ext_ok"},  32'(ext_ok),  32'(l < 3));
  endtask

  task automatic do_read(logic [15:0] a, logic [7:0] c, bit sig, string tag);
    logic       ev;
    logic [7:0] ed;
    if (sig) begin ev = 1'b1; ed = id_exp(a); end
    else if (lvl_of(lb_m) < 2) begin ev = 1'b1; ed = ~(c ^ key_m[a[5:0]]); end
    else begin ev = 1'b0; ed = 8'h00; end
    addr = a; code_in = c; rd_verify = !sig; rd_sig = sig;
    cyc(2);
    chk({tag, " valid"}, 32'(vfy_valid), 32'(ev));
    chk({tag, " data"},  32'(vfy_data),  32'(ed));
    rd_verify = 1'b0; rd_sig = 1'b0;
    cyc(1);
  endtask

  // kind: 0 code, 1 table, 2 protection bit
  task automatic pulses(int kind, logic [15:0] a, logic [7:0] d, logic [1:0] s,
                        int n, output bit seen);
    seen = 1'b0;
    addr = a; wr_data = d; lock_sel = s;
    pgm_code = (kind == 0); pgm_key = (kind == 1); pgm_lock = (kind == 2);
    cyc(1);
    for (int i = 0; i < n; i++) begin
      pgm_strobe = 1'b1;
      cyc(1);
      seen |= code_commit;
      pgm_strobe = 1'b0;
      cyc(1);
      seen |= code_commit;
    end
    pgm_code = 1'b0; pgm_key = 1'b0; pgm_lock = 1'b0;
    cyc(4);
  endtask

  task automatic key_prog(logic [15:0] a, logic [7:0] d, string tag);
    bit seen;
    pulses(1, a, d, 2'd0, 25, seen);
    if (lvl_of(lb_m) == 0) key_m[a[5:0]] = d;
    chk({tag, " no code strobe"}, 32'(seen), 32'(0));
  endtask

  task automatic lock_prog(logic [1:0] s);
    bit seen;
    pulses(2, 16'h0, 8'h0, s, 25, seen);
    lb_m[s] = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit seen;
    logic [5:0] idx_list [8];
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) key_m[i] = 8'hFF;
    lb_m = 3'b000;
    rst = 1'b1; ea_pin = 1'b1; addr = '0; code_in = '0; wr_data = '0; lock_sel = '0;
    pgm_code = 0; pgm_key = 0; pgm_lock = 0; rd_verify = 0; rd_sig = 0;
    pgm_strobe = 0; wipe = 0;
    cyc(3);
    // R5: flags are all low while reset is held
    chk("R5 reset movc_ok", 32'(movc_ok), 0);
    chk("R5 reset pgm_ok",  32'(pgm_ok), 0);
    chk("R5 reset vfy_ok",  32'(vfy_ok), 0);
    chk("R5 reset ext_ok",  32'(ext_ok), 0);
    chk("R11 reset valid",  32'(vfy_valid), 0);
    chk("R3 reset commit",  32'(code_commit), 0);
    rst = 1'b0;
    cyc(2);
    check_perms("R5 level0");

    // R10 identity reads
    do_read(16'h0030, 8'h00, 1, "R10 id 30");
    do_read(16'h0031, 8'h12, 1, "R10 id 31");
    do_read(16'h0060, 8'h34, 1, "R10 id 60");
    do_read(16'h0061, 8'h00, 1, "R10 id other");
    do_read(16'h1030, 8'h00, 1, "R10 id high bits");

    // R2 blank table returns code unchanged
    for (int i = 0; i < 12; i++) do_read(16'($urandom), 8'($urandom), 0, "R2 blank");

    // R8 pass-through at level 0
    ea_pin = 1'b0; cyc(2);
    chk("R8 level0 follow low", 32'(ea_eff), 0);
    ea_pin = 1'b1; cyc(2);
    chk("R8 level0 follow high", 32'(ea_eff), 1);

    // R4 table programming: edges and random entries
    key_prog(16'h0000, 8'h5A, "R4 idx0");
    key_prog(16'h003F, 8'h00, "R4 idx63");
    idx_list[0] = 6'd0; idx_list[1] = 6'd63;
    for (int i = 2; i < 8; i++) begin
      idx_list[i] = 6'($urandom);
      key_prog({10'($urandom), idx_list[i]}, 8'($urandom), "R4 rand");
    end
    // R1 read back through aliasing upper address bits
    for (int i = 0; i < 8; i++)
      do_read({10'($urandom), idx_list[i]}, 8'($urandom), 0, "R1 programmed");
    for (int i = 0; i < 16; i++) do_read(16'($urandom), 8'($urandom), 0, "R1 random");

    // R4 24 strobes commit nothing
    pulses(1, 16'h0007, 8'h33, 2'd0, 24, seen);
    do_read(16'h0007, 8'hC3, 0, "R4 short table");

    // R3 code commit threshold
    pulses(0, 16'h0100, 8'h00, 2'd0, 5, seen);
    chk("R3 five strobes commit", 32'(seen), 1);
    pulses(0, 16'h0100, 8'h00, 2'd0, 4, seen);
    chk("R3 four strobes no commit", 32'(seen), 0);

    // R11 overlapping modes
    addr = 16'h000B; wr_data = 8'h44; pgm_code = 1; pgm_key = 1;
    cyc(1);
    for (int i = 0; i < 25; i++) begin
      pgm_strobe = 1; cyc(1);
      chk("R11 two modes no commit", 32'(code_commit), 0);
      pgm_strobe = 0; cyc(1);
    end
    pgm_code = 0; pgm_key = 0; cyc(4);
    do_read(16'h000B, 8'h6E, 0, "R11 table untouched");
    addr = 16'h0030; rd_verify = 1; rd_sig = 1; cyc(2);
    chk("R11 two reads no valid", 32'(vfy_valid), 0);
    rd_verify = 0; rd_sig = 0; cyc(2);

    // R2 wipe
    wipe = 1; cyc(1); wipe = 0; cyc(1);
    for (int i = 0; i < 64; i++) key_m[i] = 8'hFF;
    for (int i = 0; i < 4; i++) do_read({10'h0, idx_list[i]}, 8'($urandom), 0, "R2 after wipe");
    key_prog(16'h0002, 8'hA5, "R4 reprogram");
    do_read(16'h0402, 8'h0F, 0, "R1 after reprogram");

    // level 1
    lock_prog(2'd0);
    check_perms("R5 level1");
    pulses(0, 16'h0200, 8'h00, 2'd0, 5, seen);
    chk("R6 code blocked", 32'(seen), 0);
    key_prog(16'h0009, 8'h12, "R6 table blocked");
    do_read(16'h0009, 8'h77, 0, "R6 table unchanged");

    // R8 latch on reset, R9 survival of reset
    ea_pin = 1; rst = 1; cyc(2); rst = 0; cyc(1);
    ea_pin = 0; cyc(3);
    chk("R8 latched high", 32'(ea_eff), 1);
    check_perms("R9 after reset");
    ea_pin = 0; rst = 1; cyc(2); rst = 0; cyc(1);
    ea_pin = 1; cyc(3);
    chk("R8 latched low", 32'(ea_eff), 0);

    // R9 wipe keeps protection
    wipe = 1; cyc(1); wipe = 0; cyc(2);
    for (int i = 0; i < 64; i++) key_m[i] = 8'hFF;
    do_read(16'h0002, 8'h3C, 0, "R2 wipe at level1");
    check_perms("R9 after wipe");

    // level 3 through a non-cumulative combination
    lock_prog(2'd2);
    check_perms("R5 level3");
    do_read(16'h0005, 8'h99, 0, "R7 verify blocked");
    do_read(16'h0060, 8'h00, 1, "R10 id at level3");
    chk("R8 latched at level3", 32'(ea_eff), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule